// File: doc/BRIEF.md
# Edge-Interrupt GPIO Port Controller

This block is an eight-pin GPIO controller on a small byte-wide register bus. Pins 0 to 3 are driven from an output latch. Pins 4 to 7 are sensed as inputs. Every pad level is passed through a two-flop synchroniser. For each of the four input lines, two hidden flags record edges: one for rising edges and one for falling edges.

A 2-bit selector for each input line picks which of its two flags, if either, appears in the status register and contributes to the single level interrupt output. Software clears a line by writing a 1 to that line's status bit. This clears both hidden flags of the line, so software can retarget the selector after a clear without being left with a stale edge. A read of the data offset returns the synchronised pad levels, not the contents of the output latch.

Top module: `gpio_edge_irq`

## Requirements
- R1: After reset the direction register reads 0x0F, the output latch is 0x00, the interrupt configuration reads 0x00, status reads 0x00, `irq` is 0 and `gpio_oe` is 0x0F.
- R2: Registers sit at these offsets: direction at 0, data at 1, interrupt configuration at 3 and interrupt status at 4. Offsets 2 and 5 to 7 read 0x00. `rdata` is 0x00 whenever `rd_en` is low.
- R3: A write to offset 0 sets `gpio_oe`. A 1 in a bit enables that pin's driver (output) and a 0 makes it an input. The register reads back the written value.
- R4: A write to offset 1 sets `gpio_out`. A read of offset 1 returns the synchronised `pad_in` levels and never the output latch.
- R5: Input line k (k = 0..3, meaning pin 4+k) has a selector at configuration bits [2k+1:2k]. Code 01 shows the line's falling flag in status bit k, and code 10 shows its rising flag there.
- R6: The rising and falling flags of a line are independent. An edge whose flag is not currently selected is still recorded, and it appears once the selector is changed to that flag.
- R7: Writing offset 4 with bit k = 1 clears both flags of line k, whatever the selector holds. A 0 bit has no effect. Status bits 7:4 always read 0.
- R8: `irq` is high exactly while any status bit is visible as 1. It stays high until the bit is cleared or deselected.
- R9: When an edge on line k and a clearing write to bit k fall in the same clock, the edge wins and the flag stays set.
- R10: Selector code 11 behaves like 00: nothing is shown and no interrupt is raised.
- R11: A pad edge sets its flag on the third rising clock edge after the pad changes. This comes from two synchroniser flops plus the edge register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 3 | Register offset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data (combinational, zero when no read) |
| pad_in | input | 8 | Sensed pad levels of all eight pins |
| gpio_out | output | 8 | Output latch |
| gpio_oe | output | 8 | Per-pin driver enable from the direction register |
| irq | output | 1 | Level interrupt |

## Verification
The bound checker watches several properties on every clock. The interrupt may drop only in the cycle after a status or configuration write. The output and direction values hold unless their own offsets are written. Status bits 7:4 and unmapped offsets always read zero. The behaviours that depend on history can only be shown by the bench's sequences: the three-cycle synchroniser latency, a hidden falling edge revealed by a selector change, one clear removing both flags, code 11 acting as off, and an edge beating a clear in the same cycle.

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq #(
  parameter int NIN = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] addr,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic [7:0] pad_in,
  output logic [7:0] gpio_out,
  output logic [7:0] gpio_oe,
  output logic       irq
);
  localparam int W = 8;
  localparam int FIRST_IN = W - NIN;
  localparam logic [2:0] A_DIR = 3'd0, A_DAT = 3'd1, A_CFG = 3'd3, A_STS = 3'd4;

  logic [W-1:0]   dir_q, out_q, cfg_q, sync1_q, sync2_q;
  logic [NIN-1:0] prev_q, rise_q, fall_q, vis;

  wire [NIN-1:0] lvl     = sync2_q[W-1:FIRST_IN];
  wire [NIN-1:0] rise_ev = lvl & ~prev_q;
  wire [NIN-1:0] fall_ev = ~lvl & prev_q;
  wire [NIN-1:0] clr     = (wr_en && addr == A_STS) ? wdata[NIN-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q   <= 8'h0F;
      out_q   <= '0;
      cfg_q   <= '0;
      sync1_q <= '0;
      sync2_q <= '0;
      prev_q  <= '0;
      rise_q  <= '0;
      fall_q  <= '0;
    end else begin
      sync1_q <= pad_in;
      sync2_q <= sync1_q;
      prev_q  <= lvl;
      rise_q  <= rise_ev | (rise_q & ~clr);
      fall_q  <= fall_ev | (fall_q & ~clr);
      if (wr_en) begin
        case (addr)
          A_DIR:   dir_q <= wdata;
          A_DAT:   out_q <= wdata;
          A_CFG:   cfg_q <= wdata;
          default: ;
        endcase
      end
    end
  end

  for (genvar k = 0; k < NIN; k++) begin : g_sel
    wire [1:0] sel = cfg_q[2*k +: 2];
    assign vis[k] = (sel == 2'b01) ? fall_q[k] :
                    (sel == 2'b10) ? rise_q[k] : 1'b0;
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (addr)
        A_DIR:   rdata = dir_q;
        A_DAT:   rdata = sync2_q;
        A_CFG:   rdata = cfg_q;
        A_STS:   rdata = {{(W-NIN){1'b0}}, vis};
        default: rdata = '0;
      endcase
    end
  end

  assign gpio_out = out_q;
  assign gpio_oe  = dir_q;
  assign irq      = |vis;
endmodule

// File: rtl/gpio_edge_irq_chk.sv
module gpio_edge_irq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] addr,
  input logic       wr_en,
  input logic       rd_en,
  input logic [7:0] rdata,
  input logic [7:0] gpio_out,
  input logic [7:0] gpio_oe,
  input logic       irq
);
  p_irq_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(wr_en && (addr == 3'd4 || addr == 3'd3)));

  p_sts_upper_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 3'd4) |-> (rdata[7:4] == 4'h0));

  p_out_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == 3'd1) |=> $stable(gpio_out));

  p_oe_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == 3'd0) |=> $stable(gpio_oe));

  p_unmapped_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_en || addr == 3'd2 || addr > 3'd4) |-> (rdata == 8'h00));
endmodule

bind gpio_edge_irq gpio_edge_irq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
  .rdata(rdata), .gpio_out(gpio_out), .gpio_oe(gpio_oe), .irq(irq)
);

// File: tb/gpio_edge_irq_test.sv
module gpio_edge_irq_test;
  logic       clk = 0, rst_n = 0, wr_en = 0, rd_en = 0;
  logic [2:0] addr = 0;
  logic [7:0] wdata = 0, pad_in = 0, rdata, gpio_out, gpio_oe;
  logic       irq;
  int checks = 0, failures = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #4 clk = ~clk;

  gpio_edge_irq uut (.clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
    .rd_en(rd_en), .wdata(wdata), .rdata(rdata), .pad_in(pad_in),
    .gpio_out(gpio_out), .gpio_oe(gpio_oe), .irq(irq));

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rd_en && exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, rdata, e);
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    addr = a; wdata = d; wr_en = 1;
    @(posedge clk); #1;
    wr_en = 0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] e, input string t);
    @(posedge clk); #1;
    addr = a; rd_en = 1;
    exp_q.push_back(e); tag_q.push_back(t);
    @(posedge clk); #1;
    rd_en = 0;
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  task automatic finish_run;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    cyc(3); rst_n = 1; cyc(1);
    // R1 reset values
    check("R1 irq", {7'b0, irq}, 8'h00);
    check("R1 gpio_out", gpio_out, 8'h00);
    check("R1 gpio_oe", gpio_oe, 8'h0F);
    rd(0, 8'h0F, "R1 dir");
    rd(3, 8'h00, "R1 cfg");
    rd(4, 8'h00, "R1 status");
    // R2 unmapped offsets and idle read bus
    rd(2, 8'h00, "R2 offset2");
    rd(6, 8'h00, "R2 offset6");
    check("R2 idle rdata", rdata, 8'h00);
    // R4 data write vs pin readback
    wr(1, 8'h05);
    check("R4 gpio_out", gpio_out, 8'h05);
    pad_in = 8'hA0; cyc(3);
    rd(1, 8'hA0, "R4 pin readback");
    wr(4, 8'h0F);
    pad_in = 8'h00; cyc(4);
    wr(4, 8'h0F);
    // R3 direction
    wr(0, 8'h3C);
    check("R3 gpio_oe", gpio_oe, 8'h3C);
    rd(0, 8'h3C, "R3 dir readback");
    wr(0, 8'h0F);
    // R11 latency with R5 rising select on line 0
    wr(3, 8'h02);
    @(posedge clk); #1; pad_in[4] = 1;
    cyc(1); check("R11 after 1 edge", {7'b0, irq}, 8'h00);
    cyc(1); check("R11 after 2 edges", {7'b0, irq}, 8'h00);
    cyc(1); check("R11 after 3 edges", {7'b0, irq}, 8'h01);
    rd(4, 8'h01, "R5 rising shown");
    // R8 level held, R7 zero write no effect
    cyc(5); check("R8 irq held", {7'b0, irq}, 8'h01);
    wr(4, 8'h00);
    check("R7 zero write irq", {7'b0, irq}, 8'h01);
    rd(4, 8'h01, "R7 zero write status");
    wr(4, 8'h01);
    check("R8 irq after clear", {7'b0, irq}, 8'h00);
    // R6 hidden falling flag
    pad_in[4] = 0; cyc(4);
    check("R6 falling hidden irq", {7'b0, irq}, 8'h00);
    rd(4, 8'h00, "R6 falling hidden");
    wr(3, 8'h01);
    rd(4, 8'h01, "R6 falling revealed");
    check("R6 irq revealed", {7'b0, irq}, 8'h01);
    // R10 code 11 off
    wr(3, 8'h03);
    check("R10 irq code11", {7'b0, irq}, 8'h00);
    rd(4, 8'h00, "R10 status code11");
    // R7 clear removes both flags
    pad_in[4] = 1; cyc(4);
    wr(4, 8'h01);
    wr(3, 8'h02); rd(4, 8'h00, "R7 rising cleared");
    wr(3, 8'h01); rd(4, 8'h00, "R7 falling cleared");
    // R9 edge beats clear in same clock
    wr(3, 8'h02);
    pad_in[4] = 0; cyc(4); wr(4, 8'h01);
    @(posedge clk); #1; pad_in[4] = 1;
    @(posedge clk);
    wr(4, 8'h01);
    check("R9 irq edge wins", {7'b0, irq}, 8'h01);
    rd(4, 8'h01, "R9 status edge wins");
    wr(4, 8'h01);
    // R5 line 3 rising select at bits 7:6
    wr(3, 8'h80);
    pad_in[7] = 1; cyc(4);
    rd(4, 8'h08, "R5 line3 rising");
    check("R8 irq line3", {7'b0, irq}, 8'h01);
    cyc(2);
    finish_run();
  end
endmodule